// File: doc/BRIEF.md
# Multiphase Pulse-Count Amplitude Integrator

This block turns a stream of level-crossing pulses from a coarse flash quantizer into a train of transmit events. The event rate follows the mean rectified amplitude of a band-limited signal. Six pulse lines arrive: three report positive levels and three report negative levels. Their comparators are clocked on staggered phases, so at most one line is high in any cycle.

The six lines are merged into a single "hit" and counted by one shared counter. Each cycle that carries a hit adds one, so the count grows with the quantized area under the absolute value of the signal. When the count reaches a threshold chosen by a 3-bit gain code, the counter restarts and a one-cycle `fire` strobe is issued. The information is carried by the spacing between strobes, not by a stored sum. A downstream transmitter can stall the block with `tx_busy`. While it does, one event is kept for later and any further events are discarded.

Top module: `amp_pulse_integrator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count and any held event, and `fire` reads 0 in the cycle that follows.
- R2: Every cycle in which `en` is high and exactly one of the six lines (`pos_pulse[2:0]`, `neg_pulse[2:0]`) is high adds one to the count, whichever line it is. The lines are never high together.
- R3: The threshold is NTH = 2^(gain_code+2), so codes 0 to 7 give 4 to 512 hits per event.
- R4: The hit that completes a threshold returns the count to zero. Each further run of NTH hits produces exactly one more event, so no hit is lost or counted twice across a restart.
- R5: `fire` is high for the single cycle after the clock edge at which the completing hit was sampled, provided `tx_busy` is low and nothing is held.
- R6: While `en` is low, pulses are ignored, the count holds, and `fire` stays 0.
- R7: While `tx_busy` is high, `fire` stays 0. The first event in that time is held, and later ones are dropped. The held event fires in the first cycle after `tx_busy` falls.
- R8: The gain code can change at run time. If the count already meets or exceeds the new NTH, the next hit completes a threshold.
- R9: If a held event is released at the same edge as a new threshold completion, the held event fires first and the new event fires in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Integration enable |
| pos_pulse | input | 3 | Positive-level comparator pulses |
| neg_pulse | input | 3 | Negative-level comparator pulses |
| gain_code | input | 3 | Threshold select, NTH = 2^(code+2) |
| tx_busy | input | 1 | Downstream transmitter stall |
| fire | output | 1 | One-cycle packet-fire strobe |

## Verification
Two functions can fall in the same cycle: the release of a held event when `tx_busy` drops, and a fresh threshold completion. The bench provokes this at NTH = 4. It keeps `tx_busy` high through one full threshold so that an event is held, feeds three more hits, then sends the fourth hit in the same cycle that `tx_busy` falls. The result is correct only if `fire` is high in two consecutive cycles and low afterwards. A second overlap, a threshold lowered below the current count, is judged by whether the very next hit fires.

// File: rtl/api_pkg.sv
package api_pkg;
  // Number of hits per event for a given gain code.
  function automatic int unsigned nth_for(input int unsigned code,
                                          input int unsigned base);
    return 32'd1 << (code + base);
  endfunction

  // True when a count plus one more hit meets the threshold.
  function automatic logic meets(input int unsigned cnt_plus,
                                 input int unsigned thr);
    return cnt_plus >= thr;
  endfunction
endpackage

// File: rtl/api_pulse_merge.sv
module api_pulse_merge #(
  parameter int LANES = 3
) (
  input  logic [LANES-1:0] pos_in,
  input  logic [LANES-1:0] neg_in,
  output logic             hit
);
  localparam int ALL = 2 * LANES;
  logic [ALL-1:0] lines;
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lines[g]         = pos_in[g];
      assign lines[g + LANES] = neg_in[g];
    end
  endgenerate
  assign hit = |lines;
endmodule

// File: rtl/api_tick_counter.sv
module api_tick_counter
  import api_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hit,
  input  int unsigned      thr,
  output logic             reach,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  int unsigned      nxt;

  always_comb begin
    nxt   = 32'(cnt_q) + 32'd1;
    reach = en && hit && meets(nxt, thr);
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (reach) cnt_q <= '0;
    else if (en && hit) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/api_fire_gate.sv
module api_fire_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic busy,
  input  logic reach,
  output logic fire,
  output logic pend
);
  logic fire_q, pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (!en) begin
      fire_q <= 1'b0;
    end else if (busy) begin
      fire_q <= 1'b0;
      pend_q <= pend_q | reach;
    end else begin
      fire_q <= pend_q | reach;
      pend_q <= pend_q & reach;
    end
  end

  assign fire = fire_q;
  assign pend = pend_q;
endmodule

// File: rtl/amp_pulse_integrator.sv
module amp_pulse_integrator
  import api_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int GAIN_W     = 3,
  parameter int BASE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LANES-1:0]  pos_pulse,
  input  logic [LANES-1:0]  neg_pulse,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              tx_busy,
  output logic              fire
);
  localparam int CNT_W = BASE_SHIFT + (1 << GAIN_W);

  logic             hit;
  logic             reach;
  logic             pend;
  logic [CNT_W-1:0] cnt;
  int unsigned      thr;

  assign thr = nth_for(32'(gain_code), BASE_SHIFT);

  api_pulse_merge #(.LANES(LANES)) merge_i (
    .pos_in(pos_pulse), .neg_in(neg_pulse), .hit(hit)
  );

  api_tick_counter #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .en(en), .hit(hit), .thr(thr),
    .reach(reach), .cnt(cnt)
  );

  api_fire_gate gate_i (
    .clk(clk), .rst(rst), .en(en), .busy(tx_busy), .reach(reach),
    .fire(fire), .pend(pend)
  );
endmodule

// File: rtl/api_chk.sv
module api_chk #(
  parameter int LANES = 3,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             tx_busy,
  input logic [LANES-1:0] pos_pulse,
  input logic [LANES-1:0] neg_pulse,
  input logic             hit,
  input logic             reach,
  input logic [CNT_W-1:0] cnt,
  input logic             fire
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !fire));
  // R2
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pos_pulse, neg_pulse}));
  // R2
  hit_adds_one_chk: assert property (@(posedge clk) disable iff (rst)
    (en && hit && !reach) |=> cnt == $past(cnt) + 1'b1);
  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reach |=> cnt == '0);
  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt) && !fire));
  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> !fire);
endmodule

bind amp_pulse_integrator api_chk #(.LANES(LANES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .tx_busy(tx_busy),
  .pos_pulse(pos_pulse), .neg_pulse(neg_pulse),
  .hit(hit), .reach(reach), .cnt(cnt), .fire(fire)
);

// File: tb/amp_pulse_integrator_tb.sv
module amp_pulse_integrator_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [2:0] pos_pulse = '0;
  logic [2:0] neg_pulse = '0;
  logic [2:0] gain_code = '0;
  logic tx_busy = 1'b0;
  logic fire;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  amp_pulse_integrator dut_i (
    .clk(clk), .rst(rst), .en(en), .pos_pulse(pos_pulse),
    .neg_pulse(neg_pulse), .gain_code(gain_code), .tx_busy(tx_busy),
    .fire(fire)
  );

  task automatic check(input logic got, input logic exp, input string rq);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s fire=%b expected=%b at %0t", rq, got, exp, $time);
    end
  endtask

  // drive one cycle at a falling edge, sample at the next falling edge
  task automatic step(input logic [5:0] ln, input logic e, input logic b,
                      input logic expf, input string rq);
    pos_pulse = ln[2:0];
    neg_pulse = ln[5:3];
    en = e;
    tx_busy = b;
    @(negedge clk);
    check(fire, expf, rq);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pos_pulse = '0; neg_pulse = '0; en = 1'b0; tx_busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(fire, 1'b0, "R1");
    rst = 1'b0;
  endtask

  function automatic logic [5:0] lane(input int k);
    return 6'b1 << (k % 6);
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    // R2 R3 R4 R5: sweep every gain code, rotating through all six lines
    for (int c = 0; c < 8; c++) begin
      int n;
      n = 1 << (c + 2);
      gain_code = 3'(c);
      do_reset();
      for (int k = 1; k <= 2 * n + 1; k++) begin
        if (k % 5 == 0) step(6'b0, 1'b1, 1'b0, 1'b0, "R5");
        step(lane(k), 1'b1, 1'b0, (k % n) == 0, "R3_R4");
      end
    end
    // R1: reset in the middle of a count
    gain_code = 3'd0;
    do_reset();
    for (int k = 1; k <= 3; k++) step(lane(k), 1'b1, 1'b0, 1'b0, "R1");
    rst = 1'b1;
    step(6'b0, 1'b1, 1'b0, 1'b0, "R1");
    rst = 1'b0;
    for (int k = 1; k <= 4; k++) step(lane(k), 1'b1, 1'b0, k == 4, "R1");
    // R6: disabled cycles ignore pulses and hold the count
    do_reset();
    for (int k = 1; k <= 2; k++) step(lane(k), 1'b1, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 6; k++) step(lane(k), 1'b0, 1'b0, 1'b0, "R6");
    step(lane(2), 1'b1, 1'b0, 1'b0, "R6");
    step(lane(3), 1'b1, 1'b0, 1'b1, "R6");
    // R7: busy holds one event, drops the rest
    do_reset();
    for (int k = 1; k <= 12; k++) step(lane(k), 1'b1, 1'b1, 1'b0, "R7");
    step(6'b0, 1'b1, 1'b0, 1'b1, "R7");
    step(6'b0, 1'b1, 1'b0, 1'b0, "R7");
    step(6'b0, 1'b1, 1'b0, 1'b0, "R7");
    for (int k = 1; k <= 4; k++) step(lane(k), 1'b1, 1'b0, k == 4, "R7");
    // R8: lowering the threshold below the current count
    gain_code = 3'd3;
    do_reset();
    for (int k = 1; k <= 10; k++) step(lane(k), 1'b1, 1'b0, 1'b0, "R8");
    gain_code = 3'd0;
    step(lane(0), 1'b1, 1'b0, 1'b1, "R8");
    for (int k = 1; k <= 4; k++) step(lane(k), 1'b1, 1'b0, k == 4, "R8");
    // R9: held release coincides with a fresh completion
    do_reset();
    for (int k = 1; k <= 7; k++) step(lane(k), 1'b1, 1'b1, 1'b0, "R9");
    step(lane(8), 1'b1, 1'b0, 1'b1, "R9");
    step(6'b0, 1'b1, 1'b0, 1'b1, "R9");
    step(6'b0, 1'b1, 1'b0, 1'b0, "R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule